// File: doc/BRIEF.md
# Sequenced Flag-Threshold Register File

This block keeps the two programmable thresholds of a synchronous FIFO. One threshold sets the almost-empty level and the other sets the almost-full level. Each threshold is stored as a low byte and a high byte, so there are four byte registers. There is no address bus. Every qualified clock edge works on the register that a cyclic selector points at, and the selector then moves on to the next register. Writes come from the low byte of the FIFO data input on the write clock. Read-back goes to the data output on the read clock.

A strap input is sampled while reset is asserted, and it decides how the load pin behaves. If the load pin is low during reset, the block runs in threshold-programming mode. In that mode, holding the load pin low turns write and read cycles into register accesses, and the normal FIFO transfers are held back. If the load pin is high during reset, the pin acts as a second write enable and the thresholds keep their defaults. The block supplies the combined thresholds to the FIFO flag logic and gives the FIFO its qualified write and read requests.

Top module: `ofs_seqfile`

## Requirements
- R1: Reset behaviour:
  - Both thresholds return to 7.
  - `rb_data` clears to 0 and `rb_valid` goes low.
  - The write selector and the read selector both point at the empty-low register.
- R2: Mode strap:
  - `ld_n` low while `rst` is high selects programming mode, shown by `prog_mode` = 1.
  - `ld_n` high while `rst` is high selects two-enable mode.
  - In two-enable mode no threshold register is ever written or read back.
- R3: In programming mode, a write-clock edge with `ld_n`=0 and `wen_n`=0 stores `cfg_din` in the selected register. The write selector then advances through this order: empty-low (0), empty-high (1), full-low (2), full-high (3).
- R4: After a write to full-high (3), the next qualified write goes to empty-low (0).
- R5: A selector keeps its position while `ld_n` is high, so a later load access continues at the next register in the sequence.
- R6: A write-clock edge with `ld_n`=0 and `wen_n`=1 changes no threshold and does not move the write selector.
- R7: Read-back in programming mode:
  - A read-clock edge with `ld_n`=0, `ren1_n`=0 and `ren2_n`=0 loads `rb_data` with the selected register, zero-extended.
  - `rb_valid` is 1 in the following cycle.
  - The read selector steps through the same order as the write selector and is independent of it.
- R8: A high byte keeps only clog2(DEPTH)-8 bits, and its unused bits read back as 0. `ae_offset` and `af_offset` are each {high byte, low byte}.
- R9: `fifo_wr_req` is 1 exactly when `wen_n`=0 and `ld_n`=1, in either mode.
- R10: `fifo_rd_req` is 1 exactly when both read enables are 0 and the block is not in programming mode with `ld_n`=0.
- R11: Without a read-back edge, `rb_data` holds its value and `rb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| ld_n | input | 1 | Load control, active low; acts as the mode strap during reset |
| wen_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| cfg_din | input | 8 | Low byte of the FIFO data input, used for threshold writes |
| rb_data | output | DATA_W | Read-back value, zero-extended |
| rb_valid | output | 1 | Read-back happened on the previous read-clock edge |
| ae_offset | output | clog2(DEPTH) | Almost-empty threshold |
| af_offset | output | clog2(DEPTH) | Almost-full threshold |
| prog_mode | output | 1 | Programming mode latched at reset |
| fifo_wr_req | output | 1 | Qualified FIFO data write request |
| fifo_rd_req | output | 1 | Qualified FIFO data read request |

## Verification
Directed sequences cover several cases:
- A partial load of two registers, followed by an exit and a resumed load, shows whether the selector position survives leaving load mode.
- A run of five writes shows whether the sequence wraps correctly.
- Writing 0xFF into a high byte and reading it back shows whether the unused bits are masked.

Random mixes of writes, reads, no-operation cycles and normal FIFO cycles then separate the write selector from the read selector, because they drift apart. A second reset with the strap high confirms that the same pin patterns leave the thresholds untouched in two-enable mode. A final reset confirms that the selectors restart at empty-low.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 4;

  // Access order is behaviour: the selector walks these codes in sequence.
  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofs_sel_e;

  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    logic [1:0] nxt;
    nxt = cur + 2'd1;
    return ofs_sel_e'(nxt);
  endfunction
endpackage

// File: rtl/ofs_mode_strap.sv
// Captures the load pin while reset is held; the value is frozen afterwards.
module ofs_mode_strap (
  input  logic clk,
  input  logic rst,
  input  logic ld_n,
  output logic prog_mode
);
  always_ff @(posedge clk) begin
    if (rst) prog_mode <= ~ld_n;
  end
endmodule

// File: rtl/ofs_seq_ptr.sv
// Cyclic four-step selector, one per clock domain.
module ofs_seq_ptr import ofs_seq_pkg::*; (
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  output ofs_sel_e sel
);
  always_ff @(posedge clk) begin
    if (rst)       sel <= SEL_EMPTY_LO;
    else if (step) sel <= next_sel(sel);
  end
endmodule

// File: rtl/ofs_store.sv
// Threshold storage in the write-clock domain. Each threshold is a
// full low byte plus only the high bits the depth needs.
module ofs_store import ofs_seq_pkg::*; #(
  parameter int OFS_W       = 10,
  parameter int DEFAULT_OFS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  ofs_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);
  localparam int HI_W = OFS_W - BYTE_W;
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEFAULT_OFS);

  logic [OFS_W-1:0] ofs [2];

  for (genvar g = 0; g < 2; g++) begin : g_thr
    localparam ofs_sel_e LO_SEL = (g == 0) ? SEL_EMPTY_LO : SEL_FULL_LO;
    localparam ofs_sel_e HI_SEL = (g == 0) ? SEL_EMPTY_HI : SEL_FULL_HI;
    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= DEF_V[BYTE_W-1:0];
        hi_q <= DEF_V[OFS_W-1:BYTE_W];
      end else if (wr) begin
        if (sel == LO_SEL) lo_q <= wdata;
        if (sel == HI_SEL) hi_q <= wdata[HI_W-1:0];
      end
    end

    assign ofs[g] = {hi_q, lo_q};
  end

  assign ae_ofs = ofs[0];
  assign af_ofs = ofs[1];
endmodule

// File: rtl/ofs_readback.sv
// Read-clock domain: picks the selected byte and registers it for output.
module ofs_readback import ofs_seq_pkg::*; #(
  parameter int OFS_W  = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  ofs_sel_e          sel,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_valid
);
  localparam int HI_W = OFS_W - BYTE_W;
  localparam int PAD  = BYTE_W - HI_W;

  logic [BYTE_W-1:0] pick;

  always_comb begin
    unique case (sel)
      SEL_EMPTY_LO: pick = ae_ofs[BYTE_W-1:0];
      SEL_EMPTY_HI: pick = {{PAD{1'b0}}, ae_ofs[OFS_W-1:BYTE_W]};
      SEL_FULL_LO:  pick = af_ofs[BYTE_W-1:0];
      default:      pick = {{PAD{1'b0}}, af_ofs[OFS_W-1:BYTE_W]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_data  <= '0;
      rb_valid <= 1'b0;
    end else begin
      rb_valid <= rd;
      if (rd) rb_data <= {{(DATA_W-BYTE_W){1'b0}}, pick};
    end
  end
endmodule

// File: rtl/ofs_seqfile.sv
module ofs_seqfile import ofs_seq_pkg::*; #(
  parameter int DEPTH       = 1024,
  parameter int DATA_W      = 9,
  parameter int DEFAULT_OFS = 7
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst,
  input  logic                     ld_n,
  input  logic                     wen_n,
  input  logic                     ren1_n,
  input  logic                     ren2_n,
  input  logic [7:0]               cfg_din,
  output logic [DATA_W-1:0]        rb_data,
  output logic                     rb_valid,
  output logic [$clog2(DEPTH)-1:0] ae_offset,
  output logic [$clog2(DEPTH)-1:0] af_offset,
  output logic                     prog_mode,
  output logic                     fifo_wr_req,
  output logic                     fifo_rd_req
);
  localparam int OFS_W = $clog2(DEPTH);

  logic     prog_w, prog_r;
  logic     wr_hit, rd_hit;
  ofs_sel_e wsel, rsel;

  ofs_mode_strap u_strap_w (.clk(wclk), .rst(rst), .ld_n(ld_n), .prog_mode(prog_w));
  ofs_mode_strap u_strap_r (.clk(rclk), .rst(rst), .ld_n(ld_n), .prog_mode(prog_r));

  assign wr_hit = prog_w & ~ld_n & ~wen_n;
  assign rd_hit = prog_r & ~ld_n & ~ren1_n & ~ren2_n;

  // In either mode a data write needs the load pin high.
  assign fifo_wr_req = ~wen_n & ld_n;
  assign fifo_rd_req = ~ren1_n & ~ren2_n & ~(prog_r & ~ld_n);
  assign prog_mode   = prog_w;

  ofs_seq_ptr u_wptr (.clk(wclk), .rst(rst), .step(wr_hit), .sel(wsel));
  ofs_seq_ptr u_rptr (.clk(rclk), .rst(rst), .step(rd_hit), .sel(rsel));

  ofs_store #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_store (
    .clk(wclk), .rst(rst), .wr(wr_hit), .sel(wsel), .wdata(cfg_din),
    .ae_ofs(ae_offset), .af_ofs(af_offset)
  );

  ofs_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rb (
    .clk(rclk), .rst(rst), .rd(rd_hit), .sel(rsel),
    .ae_ofs(ae_offset), .af_ofs(af_offset),
    .rb_data(rb_data), .rb_valid(rb_valid)
  );
endmodule

// File: rtl/ofs_seqfile_chk.sv
module ofs_seqfile_chk #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 9
) (
  input logic                     wclk,
  input logic                     rclk,
  input logic                     rst,
  input logic                     ld_n,
  input logic                     wen_n,
  input logic                     prog_w,
  input logic                     prog_r,
  input logic                     wr_hit,
  input logic                     rd_hit,
  input logic [1:0]               wsel_b,
  input logic [1:0]               rsel_b,
  input logic [$clog2(DEPTH)-1:0] ae_offset,
  input logic [$clog2(DEPTH)-1:0] af_offset,
  input logic [DATA_W-1:0]        rb_data,
  input logic                     rb_valid,
  input logic                     fifo_wr_req,
  input logic                     fifo_rd_req
);
  localparam int HI_W = $clog2(DEPTH) - 8;

  assert_wr_advance_R3: assert property (@(posedge wclk) disable iff (rst)
    wr_hit |=> wsel_b == 2'($past(wsel_b) + 2'd1));

  assert_wr_wrap_R4: assert property (@(posedge wclk) disable iff (rst)
    (wr_hit && wsel_b == 2'd3) |=> wsel_b == 2'd0);

  assert_ptr_hold_R5: assert property (@(posedge wclk) disable iff (rst)
    !wr_hit |=> $stable(wsel_b));

  assert_rptr_hold_R5: assert property (@(posedge rclk) disable iff (rst)
    !rd_hit |=> $stable(rsel_b));

  assert_noop_R6: assert property (@(posedge wclk) disable iff (rst)
    (prog_w && !ld_n && wen_n) |=> ($stable(ae_offset) && $stable(af_offset)));

  assert_two_enable_R2: assert property (@(posedge wclk) disable iff (rst)
    !prog_w |=> ($stable(ae_offset) && $stable(af_offset)));

  assert_rb_valid_R7: assert property (@(posedge rclk) disable iff (rst)
    rd_hit |=> rb_valid);

  assert_rb_hold_R11: assert property (@(posedge rclk) disable iff (rst)
    !rd_hit |=> ($stable(rb_data) && !rb_valid));

  assert_hi_mask_R8: assert property (@(posedge rclk) disable iff (rst)
    (rd_hit && rsel_b[0]) |=> rb_data[DATA_W-1:HI_W] == '0);

  assert_wr_gate_R9: assert property (@(posedge wclk) disable iff (rst)
    !ld_n |-> !fifo_wr_req);

  assert_rd_block_R10: assert property (@(posedge rclk) disable iff (rst)
    (prog_r && !ld_n) |-> !fifo_rd_req);
endmodule

bind ofs_seqfile ofs_seqfile_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .ld_n(ld_n), .wen_n(wen_n),
  .prog_w(prog_w), .prog_r(prog_r), .wr_hit(wr_hit), .rd_hit(rd_hit),
  .wsel_b(wsel), .rsel_b(rsel), .ae_offset(ae_offset), .af_offset(af_offset),
  .rb_data(rb_data), .rb_valid(rb_valid),
  .fifo_wr_req(fifo_wr_req), .fifo_rd_req(fifo_rd_req)
);

// File: tb/ofs_seqfile_tb.sv
module ofs_seqfile_tb;
  localparam int DEPTH  = 1024;
  localparam int DATA_W = 9;
  localparam int OFS_W  = 10;
  localparam int HI_W   = OFS_W - 8;
  localparam logic [7:0] HI_MASK = 8'((1 << HI_W) - 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, ld_n = 1'b1, wen_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [7:0]        cfg_din = '0;
  logic [DATA_W-1:0] rb_data;
  logic              rb_valid, prog_mode, fifo_wr_req, fifo_rd_req;
  logic [OFS_W-1:0]  ae_offset, af_offset;

  ofs_seqfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .wclk(clk), .rclk(clk), .rst(rst), .ld_n(ld_n), .wen_n(wen_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .cfg_din(cfg_din),
    .rb_data(rb_data), .rb_valid(rb_valid), .ae_offset(ae_offset),
    .af_offset(af_offset), .prog_mode(prog_mode),
    .fifo_wr_req(fifo_wr_req), .fifo_rd_req(fifo_rd_req)
  );

  int n_chk = 0, n_fail = 0;

  // Reference model
  logic [7:0]        mreg [4];
  logic [1:0]        mwp, mrp;
  logic              mprog, mvalid;
  logic [DATA_W-1:0] mrb;

  function automatic logic [OFS_W-1:0] m_ae();
    return {mreg[1][HI_W-1:0], mreg[0]};
  endfunction
  function automatic logic [OFS_W-1:0] m_af();
    return {mreg[3][HI_W-1:0], mreg[2]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk(tag, "ae_offset", 32'(ae_offset), 32'(m_ae()));
    chk(tag, "af_offset", 32'(af_offset), 32'(m_af()));
    chk(tag, "rb_valid",  32'(rb_valid),  32'(mvalid));
    chk(tag, "rb_data",   32'(rb_data),   32'(mrb));
  endtask

  task automatic do_reset(input logic strap_ld);
    rst = 1'b1; ld_n = strap_ld; wen_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0; ld_n = 1'b1;
    mreg[0] = 8'd7; mreg[1] = 8'd0; mreg[2] = 8'd7; mreg[3] = 8'd0;
    mwp = 2'd0; mrp = 2'd0; mprog = ~strap_ld; mvalid = 1'b0; mrb = '0;
    chk("R1", "reset state", 32'(prog_mode), 32'(mprog));
    check_regs("R1");
  endtask

  // Drive one cycle: inputs change 1 ns after a rising edge, results are
  // sampled 1 ns after the next rising edge.
  task automatic step(input logic ld, input logic we, input logic r1, input logic r2,
                      input logic [7:0] d, input string tag);
    logic exp_wr, exp_rd, do_w, do_r;
    ld_n = ld; wen_n = we; ren1_n = r1; ren2_n = r2; cfg_din = d;
    exp_wr = ~we & ld;
    exp_rd = ~r1 & ~r2 & ~(mprog & ~ld);
    #1;
    chk("R9",  "fifo_wr_req", 32'(fifo_wr_req), 32'(exp_wr));
    chk("R10", "fifo_rd_req", 32'(fifo_rd_req), 32'(exp_rd));
    do_w = mprog & ~ld & ~we;
    do_r = mprog & ~ld & ~r1 & ~r2;
    @(posedge clk);
    #1;
    mvalid = do_r;
    if (do_r) begin
      mrb = DATA_W'(mreg[mrp]);
      mrp = mrp + 2'd1;
    end
    if (do_w) begin
      mreg[mwp] = mwp[0] ? (d & HI_MASK) : d;
      mwp = mwp + 2'd1;
    end
    check_regs(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5711));
    do_reset(1'b0);                              // R1, R2: programming mode
    @(posedge clk); #1;

    // R3: load two registers, then leave load mode
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h21, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hFE, "R3");
    chk("R8", "masked empty threshold", 32'(ae_offset), 32'h221);
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h99, "R9");   // normal FIFO write
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R10");  // normal FIFO read
    // R5: resumes at full-low
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h40, "R5");
    chk("R5", "full-low after resume", 32'(af_offset), 32'h040);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h01, "R3");
    // R4: wrap back to empty-low
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h33, "R4");
    chk("R4", "wrap to empty-low", 32'(ae_offset), 32'h233);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hAA, "R6");   // no-operation
    // R7: read back five registers in order
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
    chk("R7", "fifth read is empty-low", 32'(rb_data), 32'h033);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R11");  // one enable high: hold
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R11");  // load high: FIFO read, hold

    // R8: unused high bits read as zero
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, "R8");   // write lands on empty-high
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R8");   // read pointer at empty-high
    chk("R8", "high byte read-back", 32'(rb_data), 32'h003);

    // Random mix in programming mode; never read and write together
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 5);
      d  = 8'($urandom);
      case (op)
        0: step(1'b0, 1'b0, 1'b1, 1'b1, d, "R3");
        1: step(1'b0, 1'b1, 1'b0, 1'b0, d, "R7");
        2: step(1'b0, 1'b1, 1'b1, 1'b1, d, "R6");
        3: step(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), d, "R5");
        default: step(1'b0, 1'b1, 1'($urandom), 1'b1, d, "R11");
      endcase
    end

    // R2: two-enable mode ignores the load pattern
    do_reset(1'b1);
    @(posedge clk); #1;
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h5C, "R2");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R2");
    chk("R2", "thresholds kept", 32'(ae_offset), 32'h007);
    for (int i = 0; i < 200; i++)
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "R2");

    // R1: reset restarts the selectors at empty-low
    do_reset(1'b0);
    @(posedge clk); #1;
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h55, "R1");
    chk("R1", "first write after reset", 32'(ae_offset), 32'h055);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R1");
    chk("R1", "first read after reset", 32'(rb_data), 32'h055);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule